// File: doc/BRIEF.md
# Toggle-Flag Word Crossing

This block moves single data words from a fast source clock domain into a slower destination clock domain. An accepted word goes into a holding register in the source domain, and a single flag bit is inverted there. The block has no return handshake. The destination domain passes the flag through a synchronizer chain and keeps a delayed copy of the synchronized flag. It detects a transfer as a difference between the two.

The word is loaded into the destination output register one destination cycle after detection, not in the cycle of detection. By then every bit of the held word has had a full destination period to settle. The output register then shows the word, and a valid pulse marks the cycle in which it first appears.

The source sees a busy level after each accepted strobe. Busy stays high for a fixed number of source cycles, chosen to cover the synchronizer delay and the destination load. Strobes that arrive while busy is high are dropped. Because of this, the flag cannot toggle twice within one destination period, and the held word cannot change before the destination has loaded it.

Top module: `flag_xfer`

## Requirements
- R1: While `rst_ni` is low, `src_busy_o`, `dst_valid_o` and `dst_data_o` are all zero.
- R2: A strobe on `src_load_i` sampled with `src_busy_o` low is accepted. `src_busy_o` is high for exactly BUSY_CYCLES source cycles, starting in the cycle after the accepting edge. It is then low for at least one cycle before the next word can be accepted.
- R3: A strobe sampled while `src_busy_o` is high is ignored. It is never delivered, it does not lengthen the busy period, and the held word and the flag stay unchanged.
- R4: Every accepted word appears on `dst_data_o` bit for bit, with `dst_valid_o` high for exactly one destination cycle.
- R5: Assume no destination edge coincides with a source edge. Then `dst_valid_o` rises on the (SYNC_STAGES+2)-th destination edge after the source edge that accepted the word. That is one destination edge after the change is detected, never on the detection edge itself.
- R6: While `dst_valid_o` is low, `dst_data_o` keeps the last delivered word (zero after reset).
- R7: Words are delivered in acceptance order. None is lost and none is repeated, even when the source holds its strobe high through the busy period and so chains words at the minimum spacing of BUSY_CYCLES+1 source cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Source (fast) clock |
| dst_clk_i | input | 1 | Destination (slow) clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| src_load_i | input | 1 | Source strobe offering a new word |
| src_data_i | input | DATA_W | Word offered with the strobe |
| src_busy_o | output | 1 | High while a transfer is in flight; strobes are dropped |
| dst_data_o | output | DATA_W | Last word delivered into the destination domain |
| dst_valid_o | output | 1 | One-cycle pulse when a new word first appears |

## Verification
The bench runs a clock ratio of four with offset edges, so the latency is exact. It sweeps the idle gap before each strobe across every phase of the destination clock.

Some transfers hammer the strobe with a corrupted word during the busy period. A design that accepted strobes while busy would deliver that word, or would lose the original one. Other transfers hold the strobe high into the last busy cycle, so the next word is chained at minimum spacing. A busy counter off by one would either catch the chained word on the last busy edge or leave busy high for an extra cycle, and the exact busy-length check reports both.

Every delivery is timed in destination edges. A design that loads on the detection edge arrives one edge early, and a missing synchronizer stage shifts the latency. The quiet periods between transfers are watched for any output change, and the total delivery count exposes lost or duplicated words.

// File: rtl/fx_pkg.sv
package fx_pkg;
  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_HOLD = 1'b1
  } tx_state_e;
endpackage

// File: rtl/fx_tx.sv
module fx_tx #(
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 24
) (
  input  logic              src_clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] hold_o,
  output logic              flag_o
);
  import fx_pkg::*;

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  tx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] hold_q;
  logic              flag_q;

  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      hold_q  <= '0;
      flag_q  <= 1'b0;
    end else begin
      case (state_q)
        TX_IDLE: if (load_i) begin
          hold_q  <= data_i;
          flag_q  <= ~flag_q;
          cnt_q   <= CNT_W'(BUSY_CYCLES - 1);
          state_q <= TX_HOLD;
        end
        default: begin
          if (cnt_q == '0) state_q <= TX_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
      endcase
    end
  end

  assign busy_o = (state_q == TX_HOLD);
  assign hold_o = hold_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/fx_sync.sv
module fx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fx_rx.sv
module fx_rx #(
  parameter int DATA_W = 16
) (
  input  logic              dst_clk_i,
  input  logic              rst_ni,
  input  logic              flag_s_i,
  input  logic [DATA_W-1:0] hold_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  logic              prev_q;
  logic              load_q;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  always_ff @(posedge dst_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      load_q  <= 1'b0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      prev_q  <= flag_s_i;
      // detect now, load next cycle: held word has settled by then
      load_q  <= flag_s_i ^ prev_q;
      valid_q <= load_q;
      if (load_q) data_q <= hold_i;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/flag_xfer.sv
module flag_xfer #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int BUSY_CYCLES = 24
) (
  input  logic              src_clk_i,
  input  logic              dst_clk_i,
  input  logic              rst_ni,
  input  logic              src_load_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              src_busy_o,
  output logic [DATA_W-1:0] dst_data_o,
  output logic              dst_valid_o
);
  logic [DATA_W-1:0] hold_w;
  logic              flag_w;
  logic              flag_s_w;
  logic              load_ok_w;

  assign load_ok_w = src_load_i & ~src_busy_o;

  fx_tx #(.DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) u_tx (
    .src_clk_i (src_clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_ok_w),
    .data_i    (src_data_i),
    .busy_o    (src_busy_o),
    .hold_o    (hold_w),
    .flag_o    (flag_w)
  );

  fx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (dst_clk_i),
    .rst_ni (rst_ni),
    .d_i    (flag_w),
    .q_o    (flag_s_w)
  );

  fx_rx #(.DATA_W(DATA_W)) u_rx (
    .dst_clk_i (dst_clk_i),
    .rst_ni    (rst_ni),
    .flag_s_i  (flag_s_w),
    .hold_i    (hold_w),
    .data_o    (dst_data_o),
    .valid_o   (dst_valid_o)
  );
endmodule

// File: rtl/flag_xfer_chk.sv
module flag_xfer_chk #(
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 24
) (
  input logic              src_clk_i,
  input logic              dst_clk_i,
  input logic              rst_ni,
  input logic              src_load_i,
  input logic              src_busy_o,
  input logic [DATA_W-1:0] dst_data_o,
  input logic              dst_valid_o,
  input logic [DATA_W-1:0] hold_w,
  input logic              flag_w
);
  localparam int RUN_W = $clog2(BUSY_CYCLES + 2) + 1;

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni)         run_q <= '0;
    else if (src_busy_o) run_q <= run_q + 1'b1;
    else                 run_q <= '0;
  end

  p_busy_set_r2: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    (src_load_i && !src_busy_o) |=> src_busy_o);

  p_busy_len_r2: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    $fell(src_busy_o) |-> (run_q == RUN_W'(BUSY_CYCLES)));

  p_hold_frozen_r3: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    src_busy_o |=> $stable(hold_w));

  p_flag_frozen_r3: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    src_busy_o |=> $stable(flag_w));

  p_valid_pulse_r4: assert property (@(posedge dst_clk_i) disable iff (!rst_ni)
    dst_valid_o |=> !dst_valid_o);

  p_out_hold_r6: assert property (@(posedge dst_clk_i) disable iff (!rst_ni)
    !dst_valid_o |-> $stable(dst_data_o));

  always_comb begin
    if (!rst_ni) begin
      a_reset_r1: assert (!src_busy_o && !dst_valid_o && dst_data_o == '0);
    end
  end
endmodule

bind flag_xfer flag_xfer_chk #(.DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .src_clk_i   (src_clk_i),
  .dst_clk_i   (dst_clk_i),
  .rst_ni      (rst_ni),
  .src_load_i  (src_load_i),
  .src_busy_o  (src_busy_o),
  .dst_data_o  (dst_data_o),
  .dst_valid_o (dst_valid_o),
  .hold_w      (hold_w),
  .flag_w      (flag_w)
);

// File: tb/flag_xfer_tb.sv
module flag_xfer_tb;
  localparam int W       = 8;
  localparam int SYNC    = 2;
  localparam int BUSY    = 24;
  localparam int SRC_PER = 10;
  localparam int NW      = 32;

  logic         src_clk, dst_clk, rst_n;
  logic         src_load;
  logic [W-1:0] src_data;
  logic         busy, valid;
  logic [W-1:0] dst_data;

  int checks = 0, fails = 0;
  int dst_edges = 0;
  int n_rcv = 0;
  int quiet_err = 0;
  logic [W-1:0] exp_mem [NW];
  int           acc_edge [NW];
  logic [W-1:0] last_data;
  logic         prev_valid;

  flag_xfer #(.DATA_W(W), .SYNC_STAGES(SYNC), .BUSY_CYCLES(BUSY)) u_dut (
    .src_clk_i   (src_clk),
    .dst_clk_i   (dst_clk),
    .rst_ni      (rst_n),
    .src_load_i  (src_load),
    .src_data_i  (src_data),
    .src_busy_o  (busy),
    .dst_data_o  (dst_data),
    .dst_valid_o (valid)
  );

  initial begin
    src_clk = 1'b0;
    forever #(SRC_PER/2) src_clk = ~src_clk;
  end

  // destination runs 4x slower, offset so no edge meets a source edge
  initial begin
    dst_clk = 1'b0;
    #3;
    forever #(SRC_PER*2) dst_clk = ~dst_clk;
  end

  always @(posedge dst_clk) dst_edges++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic logic [W-1:0] word_of(input int i);
    if (i == 0)      return '0;
    else if (i == 1) return '1;
    else             return W'(i * 59 + 17);
  endfunction

  // destination monitor
  initial begin
    last_data  = '0;
    prev_valid = 1'b0;
    forever begin
      @(negedge dst_clk);
      if (rst_n) begin
        if (valid) begin
          if (prev_valid) check(1'b0, "R4 pulse width", 2, 1);
          if (n_rcv < NW) begin
            check(dst_data == exp_mem[n_rcv], "R4 data", int'(dst_data), int'(exp_mem[n_rcv]));
            check(dst_edges - acc_edge[n_rcv] == SYNC + 2, "R5 latency",
                  dst_edges - acc_edge[n_rcv], SYNC + 2);
          end
          n_rcv++;
        end else if (dst_data != last_data) begin
          quiet_err++;
        end
        last_data  = dst_data;
        prev_valid = valid;
      end
    end
  end

  initial begin
    #(SRC_PER * 200000);
    check(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    rst_n    = 1'b0;
    src_load = 1'b0;
    src_data = '0;
    #47;
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(valid == 1'b0, "R1 valid", int'(valid), 0);
    check(dst_data == '0, "R1 data", int'(dst_data), 0);
    #50;
    rst_n = 1'b1;
    @(negedge src_clk);
    check(busy == 1'b0, "R1 busy after release", int'(busy), 0);

    for (int i = 0; i < NW; i++) begin
      int  gap;
      bit  junk, chain;
      gap   = i % 4;
      junk  = ((i / 4) % 2) == 1;
      chain = ((i / 8) % 2) == 1 && (i + 1 < NW);
      src_load    = 1'b1;
      src_data    = word_of(i);
      exp_mem[i]  = word_of(i);
      @(posedge src_clk);
      acc_edge[i] = dst_edges;
      for (int c = 0; c < BUSY; c++) begin
        @(negedge src_clk);
        check(busy == 1'b1, "R2 busy held", int'(busy), 1);
        if (c < BUSY - 1) begin
          // R3: strobes during busy carry a corrupted word
          src_load = junk;
          src_data = ~word_of(i);
        end else begin
          src_load = chain;
          src_data = chain ? word_of(i + 1) : '0;
        end
      end
      @(negedge src_clk);
      check(busy == 1'b0, "R2 busy drop", int'(busy), 0);
      if (!chain) begin
        src_load = 1'b0;
        for (int g = 0; g < gap; g++) @(negedge src_clk);
      end
    end
    src_load = 1'b0;
    repeat (12) @(negedge dst_clk);
    check(n_rcv == NW, "R7 delivery count", n_rcv, NW);
    check(quiet_err == 0, "R6 output held", quiet_err, 0);
    check(busy == 1'b0, "R3 no late busy", int'(busy), 0);
    report();
  end
endmodule